// File: doc/BRIEF.md
# Peak-Hold ADC Conversion Sequencer

This block drives the ADC that digitizes one detector channel. Two comparator inputs reach it with no timing relation to its clock. One marks that a pulse has started. The other marks the shaped pulse passing through its maximum. The block brings both into the clock domain. It powers the ADC up as soon as a pulse starts, and it runs a convert phase and then a read phase once the peak comparator drops. It then hands the digitized value to the next stage as a single-cycle result.

The block also guards the baseline-restore circuit. It issues a reset pulse to that circuit in two cases: a started pulse never shows a peak before a timeout, or the circuit's own flag stays raised for too long. While the channel is quiet, the block takes a forced sample at a fixed period so that a noise histogram can be built. These samples carry a flag on the result. A forced sample gives way at once to a real pulse that starts during it.

Top module: `peak_adc_seq`

## Requirements
- R1: When the pulse-start input rises while the ADC is asleep, `adc_wake` goes high exactly SYNC_STAGES+1 clocks later (3 clocks, 12 ns at defaults). Elaboration rejects a parameter set in which this exceeds the 400 ns wake limit.
- R2: While awake for a pulse, a falling edge of the peak input raises `adc_convert` exactly SYNC_STAGES+1 clocks after the edge. It stays high for CONV_CYC clocks.
- R3: `adc_read` is high for READ_CYC clocks, starting in the clock right after the last convert clock. `adc_convert` and `adc_read` are never high together.
- R4: One clock after the last read clock, `res_valid` is high for exactly one clock. At that point `res_data` holds the `adc_data` value of the last read clock, `res_noise` is 0 for a pulse result, and `adc_wake` is low.
- R5: If no peak falling edge arrives within PEAK_TIMEOUT_CYC clocks of waking for a pulse, then `adc_wake` drops, `blr_reset` is high for BLR_PULSE_CYC clocks, and no convert or result occurs.
- R6: If the baseline-restore flag input stays high for BLR_HOLD_CYC clocks, `blr_reset` pulses for BLR_PULSE_CYC clocks. A shorter high period gives no pulse.
- R7: After the pulse-start input has been low for NOISE_PERIOD_CYC clocks while asleep, the block wakes the ADC and waits SETTLE_CYC clocks. It then runs the convert and read phases and delivers a result with `res_noise` = 1.
- R8: A rising edge of the pulse-start input during a forced sample cancels that sample. No noise result is produced. The ADC stays awake and the sequence continues as a pulse, whose result carries `res_noise` = 0.
- R9: Any pulse-start activity restarts the quiet interval. With pulses spaced closer than NOISE_PERIOD_CYC, no noise sample is taken.
- R10: While `rst_n` is low, all outputs are 0.
- R11: A falling edge of the peak input while asleep has no effect, and no convert occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| valid_in | input | 1 | Asynchronous pulse-start comparator |
| peak_in | input | 1 | Asynchronous peak comparator; the falling edge marks the peak |
| blr_flag_in | input | 1 | Asynchronous baseline-restore status flag |
| adc_data | input | DATA_W | ADC parallel output |
| adc_wake | output | 1 | ADC power-up enable |
| adc_convert | output | 1 | ADC convert strobe |
| adc_read | output | 1 | ADC read strobe |
| blr_reset | output | 1 | Baseline-restore reset pulse |
| res_valid | output | 1 | One-clock result strobe |
| res_data | output | DATA_W | Digitized value |
| res_noise | output | 1 | Result came from a forced noise sample |

## Verification
A clean pulse, with the pulse-start edge followed later by the peak drop, is applied with different data words. This measures the exact wake and convert latencies and separates a correct capture from a stale or misplaced one. A pulse with no peak separates the timeout path from normal conversion. Long quiet periods, a pulse-start edge in the middle of a forced sample, and pulses spaced inside the quiet interval show whether a noise sample is started, cancelled or suppressed at the right time. Short and long holds of the baseline flag, and a peak edge while asleep, test the monitor threshold and that stray edges are ignored.

// File: rtl/peak_seq_pkg.sv
package peak_seq_pkg;
   typedef enum logic [1:0] {
      ST_SLEEP = 2'd0,
      ST_ARMED = 2'd1,
      ST_CONV  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/peak_seq_sync.sv
module peak_seq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 1) begin : g_bad_stages
      $error("peak_seq_sync: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("peak_seq_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= din;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/peak_seq_blr.sv
module peak_seq_blr #(
   parameter int HOLD_CYC  = 500,
   parameter int PULSE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_s,
   input  logic kick,
   output logic blr_reset
);
   if (HOLD_CYC < 2) begin : g_bad_hold
      $error("peak_seq_blr: HOLD_CYC must be at least 2");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("peak_seq_blr: PULSE_CYC must be at least 1");
   end

   localparam int HW = $clog2(HOLD_CYC + 1);
   localparam int PW = $clog2(PULSE_CYC + 1);

   logic [HW-1:0] hold_q;
   logic [PW-1:0] pulse_q;
   logic          hold_hit;
   logic          fire;

   assign hold_hit = flag_s && (hold_q == HW'(HOLD_CYC - 1));
   assign fire     = kick || hold_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         pulse_q <= '0;
      end else begin
         if (!flag_s || hold_hit) hold_q <= '0;
         else                     hold_q <= hold_q + 1'b1;

         if (fire)                pulse_q <= PW'(PULSE_CYC);
         else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
      end
   end

   assign blr_reset = (pulse_q != '0);
endmodule

// File: rtl/peak_seq_ctrl.sv
module peak_seq_ctrl
   import peak_seq_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int SETTLE_CYC   = 16,
   parameter int PEAK_TIMEOUT = 1000,
   parameter int CONV_CYC     = 4,
   parameter int READ_CYC     = 3,
   parameter int NOISE_PERIOD = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_s,
   input  logic              valid_rise,
   input  logic              peak_fall,
   input  logic [DATA_W-1:0] adc_data,
   output logic              adc_wake,
   output logic              adc_convert,
   output logic              adc_read,
   output logic              timeout_kick,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              res_noise
);
   if (SETTLE_CYC < 1 || CONV_CYC < 1 || READ_CYC < 1) begin : g_bad_phase
      $error("peak_seq_ctrl: settle, convert and read lengths must be positive");
   end
   if (NOISE_PERIOD < 2 || PEAK_TIMEOUT < 2) begin : g_bad_period
      $error("peak_seq_ctrl: noise period and peak timeout must be at least 2");
   end

   localparam int CONV_END = CONV_CYC + READ_CYC - 1;
   localparam int TMAX_A   = (PEAK_TIMEOUT > SETTLE_CYC) ? PEAK_TIMEOUT : SETTLE_CYC;
   localparam int TMAX     = (TMAX_A > CONV_END + 1) ? TMAX_A : CONV_END + 1;
   localparam int TW       = $clog2(TMAX + 1);
   localparam int QW       = $clog2(NOISE_PERIOD + 1);

   seq_state_t        state_q, state_d;
   logic [TW-1:0]     tmr_q, tmr_d;
   logic [QW-1:0]     quiet_q, quiet_d;
   logic              noise_q, noise_d;
   logic              capture;
   logic              res_valid_q;
   logic [DATA_W-1:0] res_data_q;
   logic              res_noise_q;

   always_comb begin
      state_d      = state_q;
      tmr_d        = tmr_q + 1'b1;
      noise_d      = noise_q;
      timeout_kick = 1'b0;
      capture      = 1'b0;
      unique case (state_q)
         ST_SLEEP: begin
            tmr_d = '0;
            if (valid_rise) begin
               state_d = ST_ARMED;
               noise_d = 1'b0;
            end else if (quiet_q == QW'(NOISE_PERIOD - 1)) begin
               state_d = ST_ARMED;
               noise_d = 1'b1;
            end
         end
         ST_ARMED: begin
            if (noise_q) begin
               if (valid_rise) begin
                  tmr_d   = '0;
                  noise_d = 1'b0;
               end else if (tmr_q == TW'(SETTLE_CYC - 1)) begin
                  state_d = ST_CONV;
                  tmr_d   = '0;
               end
            end else begin
               if (peak_fall) begin
                  state_d = ST_CONV;
                  tmr_d   = '0;
               end else if (tmr_q == TW'(PEAK_TIMEOUT - 1)) begin
                  state_d      = ST_SLEEP;
                  tmr_d        = '0;
                  timeout_kick = 1'b1;
               end
            end
         end
         ST_CONV: begin
            if (noise_q && valid_rise) begin
               state_d = ST_ARMED;
               tmr_d   = '0;
               noise_d = 1'b0;
            end else if (tmr_q == TW'(CONV_END)) begin
               state_d = ST_SLEEP;
               tmr_d   = '0;
               capture = 1'b1;
            end
         end
         default: begin
            state_d = ST_SLEEP;
            tmr_d   = '0;
         end
      endcase

      if (state_q == ST_SLEEP && state_d == ST_SLEEP && !valid_s)
         quiet_d = quiet_q + 1'b1;
      else
         quiet_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_SLEEP;
         tmr_q       <= '0;
         quiet_q     <= '0;
         noise_q     <= 1'b0;
         res_valid_q <= 1'b0;
         res_data_q  <= '0;
         res_noise_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         tmr_q       <= tmr_d;
         quiet_q     <= quiet_d;
         noise_q     <= noise_d;
         res_valid_q <= capture;
         if (capture) begin
            res_data_q  <= adc_data;
            res_noise_q <= noise_q;
         end
      end
   end

   assign adc_wake    = (state_q != ST_SLEEP);
   assign adc_convert = (state_q == ST_CONV) && (tmr_q <  TW'(CONV_CYC));
   assign adc_read    = (state_q == ST_CONV) && (tmr_q >= TW'(CONV_CYC));
   assign res_valid   = res_valid_q;
   assign res_data    = res_data_q;
   assign res_noise   = res_noise_q;
endmodule

// File: rtl/peak_adc_seq.sv
module peak_adc_seq #(
   parameter int DATA_W           = 12,
   parameter int SYNC_STAGES      = 2,
   parameter int CLK_PERIOD_NS    = 4,
   parameter int WAKE_LIMIT_NS    = 400,
   parameter int PEAK_RISE_NS     = 2500,
   parameter int SETTLE_CYC       = 16,
   parameter int PEAK_TIMEOUT_CYC = 1000,
   parameter int CONV_CYC         = 4,
   parameter int READ_CYC         = 3,
   parameter int NOISE_PERIOD_CYC = 2000,
   parameter int BLR_HOLD_CYC     = 500,
   parameter int BLR_PULSE_CYC    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic              peak_in,
   input  logic              blr_flag_in,
   input  logic [DATA_W-1:0] adc_data,
   output logic              adc_wake,
   output logic              adc_convert,
   output logic              adc_read,
   output logic              blr_reset,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              res_noise
);
   localparam int WAKE_LAT_NS = (SYNC_STAGES + 1) * CLK_PERIOD_NS;

   if (WAKE_LAT_NS > WAKE_LIMIT_NS) begin : g_bad_wake
      $error("peak_adc_seq: synchronizer depth breaks the wake latency limit");
   end
   if (PEAK_TIMEOUT_CYC * CLK_PERIOD_NS <= PEAK_RISE_NS) begin : g_bad_timeout
      $error("peak_adc_seq: peak timeout shorter than the pulse rise time");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("peak_adc_seq: DATA_W must be positive");
   end

   logic [2:0] raw_in, sync_out;
   logic       valid_s, peak_s, blr_flag_s;
   logic       valid_d, peak_d;
   logic       valid_rise, peak_fall;
   logic       timeout_kick;

   assign raw_in = {blr_flag_in, peak_in, valid_in};

   peak_seq_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_in),
      .dout  (sync_out)
   );

   assign valid_s    = sync_out[0];
   assign peak_s     = sync_out[1];
   assign blr_flag_s = sync_out[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_d <= 1'b0;
         peak_d  <= 1'b0;
      end else begin
         valid_d <= valid_s;
         peak_d  <= peak_s;
      end
   end

   assign valid_rise = valid_s & ~valid_d;
   assign peak_fall  = ~peak_s & peak_d;

   peak_seq_ctrl #(
      .DATA_W       (DATA_W),
      .SETTLE_CYC   (SETTLE_CYC),
      .PEAK_TIMEOUT (PEAK_TIMEOUT_CYC),
      .CONV_CYC     (CONV_CYC),
      .READ_CYC     (READ_CYC),
      .NOISE_PERIOD (NOISE_PERIOD_CYC)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .valid_s      (valid_s),
      .valid_rise   (valid_rise),
      .peak_fall    (peak_fall),
      .adc_data     (adc_data),
      .adc_wake     (adc_wake),
      .adc_convert  (adc_convert),
      .adc_read     (adc_read),
      .timeout_kick (timeout_kick),
      .res_valid    (res_valid),
      .res_data     (res_data),
      .res_noise    (res_noise)
   );

   peak_seq_blr #(
      .HOLD_CYC  (BLR_HOLD_CYC),
      .PULSE_CYC (BLR_PULSE_CYC)
   ) u_blr (
      .clk       (clk),
      .rst_n     (rst_n),
      .flag_s    (blr_flag_s),
      .kick      (timeout_kick),
      .blr_reset (blr_reset)
   );
endmodule

// File: rtl/peak_adc_seq_chk.sv
module peak_adc_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic adc_wake,
   input logic adc_convert,
   input logic adc_read,
   input logic res_valid,
   input logic valid_rise,
   input logic peak_fall
);
   a_r1_wake_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_wake && valid_rise) |=> adc_wake);

   a_r2_convert_awake: assert property (@(posedge clk) disable iff (!rst_n)
      adc_convert |-> adc_wake);

   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(adc_convert && adc_read));

   a_r3_read_after_convert: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_read) |-> $past(adc_convert));

   a_r4_result_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(adc_read) && !adc_read && !adc_wake));

   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   a_r11_peak_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_wake && peak_fall) |=> !adc_convert);
endmodule

bind peak_adc_seq peak_adc_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .adc_wake    (adc_wake),
   .adc_convert (adc_convert),
   .adc_read    (adc_read),
   .res_valid   (res_valid),
   .valid_rise  (valid_rise),
   .peak_fall   (peak_fall)
);

// File: tb/peak_adc_seq_test.sv
`timescale 1ns/1ps
module peak_adc_seq_test;
   localparam int DW      = 12;
   localparam int SYNC    = 2;
   localparam int SETTLE  = 16;
   localparam int TIMEOUT = 1000;
   localparam int CONV    = 4;
   localparam int READ    = 3;
   localparam int NOISE   = 2000;
   localparam int HOLD    = 500;
   localparam int PULSE   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_in = 1'b0;
   logic          peak_in = 1'b0;
   logic          blr_flag_in = 1'b0;
   logic [DW-1:0] adc_data = '0;
   logic          adc_wake, adc_convert, adc_read, blr_reset;
   logic          res_valid, res_noise;
   logic [DW-1:0] res_data;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   peak_adc_seq #(
      .DATA_W           (DW),
      .SYNC_STAGES      (SYNC),
      .SETTLE_CYC       (SETTLE),
      .PEAK_TIMEOUT_CYC (TIMEOUT),
      .CONV_CYC         (CONV),
      .READ_CYC         (READ),
      .NOISE_PERIOD_CYC (NOISE),
      .BLR_HOLD_CYC     (HOLD),
      .BLR_PULSE_CYC    (PULSE)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_in    (valid_in),
      .peak_in     (peak_in),
      .blr_flag_in (blr_flag_in),
      .adc_data    (adc_data),
      .adc_wake    (adc_wake),
      .adc_convert (adc_convert),
      .adc_read    (adc_read),
      .blr_reset   (blr_reset),
      .res_valid   (res_valid),
      .res_data    (res_data),
      .res_noise   (res_noise)
   );

   // port monitor
   logic   clr_req = 1'b0;
   int     m_conv, m_read, m_overlap, m_blr, m_res, m_noise_res;
   int     m_data, m_noise;
   always @(posedge clk) begin
      if (clr_req) begin
         m_conv = 0; m_read = 0; m_overlap = 0; m_blr = 0;
         m_res = 0; m_noise_res = 0; m_data = -1; m_noise = -1;
      end else begin
         if (adc_convert) m_conv++;
         if (adc_read) m_read++;
         if (adc_convert && adc_read) m_overlap++;
         if (blr_reset) m_blr++;
         if (res_valid) begin
            m_res++;
            if (res_noise) m_noise_res++;
            m_data  = int'(res_data);
            m_noise = int'(res_noise);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      valid_in = 1'b0; peak_in = 1'b0; blr_flag_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      clear_mon();
   endtask

   task automatic wait_result(input int limit);
      for (int i = 0; i < limit && m_res == 0; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      valid_in = 1'b1; peak_in = 1'b1; blr_flag_in = 1'b1;
      repeat (4) @(negedge clk);
      chk({adc_wake, adc_convert, adc_read, blr_reset, res_valid, res_noise} == 6'b0 && res_data == '0,
          "R10 outputs in reset", int'(adc_wake) + int'(blr_reset), 0);
      do_reset();
   endtask

   task automatic t_pulse(input logic [DW-1:0] word);
      do_reset();
      adc_data = word;
      valid_in = 1'b1; peak_in = 1'b1;
      repeat (2) @(negedge clk);
      chk(adc_wake == 1'b0, "R1 wake not before latency", int'(adc_wake), 0);
      @(negedge clk);
      chk(adc_wake == 1'b1, "R1 wake at latency", int'(adc_wake), 1);
      repeat (20) @(negedge clk);
      chk(adc_convert == 1'b0, "R2 no convert before peak", int'(adc_convert), 0);
      clear_mon();
      peak_in = 1'b0;
      repeat (2) @(negedge clk);
      chk(adc_convert == 1'b0, "R2 convert not early", int'(adc_convert), 0);
      @(negedge clk);
      chk(adc_convert == 1'b1, "R2 convert at latency", int'(adc_convert), 1);
      wait_result(40);
      chk(m_res == 1, "R4 one result", m_res, 1);
      chk(m_data == int'(word), "R4 result data", m_data, int'(word));
      chk(m_noise == 0, "R4 pulse flag", m_noise, 0);
      chk(adc_wake == 1'b0, "R4 asleep after result", int'(adc_wake), 0);
      chk(m_conv == CONV, "R2 convert width", m_conv, CONV);
      chk(m_read == READ, "R3 read width", m_read, READ);
      chk(m_overlap == 0, "R3 no overlap", m_overlap, 0);
      repeat (5) @(negedge clk);
      chk(m_res == 1, "R4 single strobe", m_res, 1);
      valid_in = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_timeout();
      do_reset();
      valid_in = 1'b1; peak_in = 1'b0;
      repeat (TIMEOUT - 10) @(negedge clk);
      chk(adc_wake == 1'b1, "R5 awake before timeout", int'(adc_wake), 1);
      repeat (40) @(negedge clk);
      chk(adc_wake == 1'b0, "R5 asleep after timeout", int'(adc_wake), 0);
      chk(m_blr == PULSE, "R5 baseline reset width", m_blr, PULSE);
      chk(m_res == 0 && m_conv == 0, "R5 no conversion", m_res + m_conv, 0);
      valid_in = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_blr();
      do_reset();
      blr_flag_in = 1'b1;
      repeat (HOLD / 2) @(negedge clk);
      blr_flag_in = 1'b0;
      repeat (20) @(negedge clk);
      chk(m_blr == 0, "R6 short flag ignored", m_blr, 0);
      blr_flag_in = 1'b1;
      repeat (HOLD + 20) @(negedge clk);
      chk(m_blr == PULSE, "R6 long flag pulses reset", m_blr, PULSE);
      blr_flag_in = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_noise();
      int t;
      do_reset();
      adc_data = 12'h3C5;
      t = 0;
      while (!adc_wake && t < NOISE + 100) begin
         @(negedge clk);
         t++;
      end
      chk(t >= NOISE - 5 && t <= NOISE + 10, "R7 noise sample period", t, NOISE);
      wait_result(SETTLE + CONV + READ + 20);
      chk(m_res == 1 && m_noise == 1, "R7 noise flag", m_noise, 1);
      chk(m_data == 'h3C5, "R7 noise data", m_data, 'h3C5);
      chk(m_conv == CONV && m_read == READ, "R7 noise phases", m_conv + m_read, CONV + READ);
   endtask

   task automatic t_abort();
      do_reset();
      adc_data = 12'h0F1;
      while (!adc_wake) @(negedge clk);
      repeat (4) @(negedge clk);
      valid_in = 1'b1; peak_in = 1'b1;
      repeat (30) @(negedge clk);
      chk(m_res == 0 && m_conv == 0, "R8 noise sample cancelled", m_res + m_conv, 0);
      chk(adc_wake == 1'b1, "R8 stays awake", int'(adc_wake), 1);
      peak_in = 1'b0;
      wait_result(40);
      chk(m_res == 1 && m_noise == 0, "R8 continues as pulse", m_noise, 0);
      valid_in = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_guard();
      do_reset();
      for (int k = 0; k < 3; k++) begin
         repeat (1500) @(negedge clk);
         valid_in = 1'b1; peak_in = 1'b1;
         repeat (10) @(negedge clk);
         peak_in = 1'b0;
         repeat (20) @(negedge clk);
         valid_in = 1'b0;
      end
      repeat (5) @(negedge clk);
      chk(m_noise_res == 0, "R9 no noise sample", m_noise_res, 0);
      chk(m_res == 3, "R9 pulse results", m_res, 3);
   endtask

   task automatic t_peak_asleep();
      do_reset();
      repeat (5) @(negedge clk);
      peak_in = 1'b1;
      repeat (10) @(negedge clk);
      peak_in = 1'b0;
      repeat (20) @(negedge clk);
      chk(m_conv == 0 && adc_wake == 1'b0, "R11 peak ignored asleep", m_conv, 0);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      t_reset();
      t_pulse(12'hA5C);
      t_pulse(12'hFFF);
      t_pulse(12'h000);
      t_timeout();
      t_blr();
      t_noise();
      t_abort();
      t_guard();
      t_peak_asleep();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule